// File: doc/BRIEF.md
# Legacy System I/O Control Register Block

This block sits on a simple byte-wide I/O port bus and answers a fixed set of single-byte port addresses. A few of them hold control state: a soft-reset bit that is driven straight onto an output, a system control byte in which only the upper four data bits are kept, and an I/O map mode bit that drives a dedicated output. A write that asks for little-endian operation cannot be honoured. Instead of changing any mode, it sets a sticky error flag.

Other ports are placeholders. Two read-only ports return an equipment byte and a board identity byte, both fixed by parameters. One read-only port always returns zero. Four write-only ports take writes and store nothing. A separate four-byte memory-mapped parity status window answers aligned 32-bit reads with zero.

Register bit fields use reversed numbering: logical bit n sits on data bit 7-n. The I/O bus uses one-cycle read and write strobes. Read data is registered.

Top module: `sysio_ctrl_regs`

## Requirements
- R1: Synchronous active-high reset sets the following: `soft_reset` 0, `endian_err` 0, `map_noncontig` 1, control byte 0 and `io_rdata` 0.
- R2: A write to port 0x092 stores data bit 0, and `soft_reset` follows it from the next cycle. A read of 0x092 returns that bit in data bit 0, with all other bits 0.
- R3: A write to port 0x092 with data bit 1 set makes `endian_err` 1 from the next cycle. The flag stays 1 until reset. Data bit 1 is never stored and never read back.
- R4: A write to port 0x81C keeps data bits 7..4 and clears bits 3..0 (mask 0xF0). A read returns the kept value.
- R5: A write to port 0x850 stores data bit 0 and drives it onto `map_noncontig` from the next cycle. A read returns it in bit 0, with all other bits 0.
- R6: Port 0x80C reads `EQUIP_VAL` and port 0x852 reads `BOARD_ID`. Writes to either port have no effect.
- R7: Port 0x818 always reads 0x00. Writes to it have no effect.
- R8: Writes to ports 0x808, 0x810, 0x812 and 0x814, or to any undecoded port, change no output and no readable state. Reads of those ports return 0xFF.
- R9: `io_rdata` takes the read value on the clock edge that samples `io_rd`. It holds that value until the next read.
- R10: A memory read with `mem_size` = 2'b10 (32-bit) at exactly address `PARITY_BASE` (default 0xBFFFEFF0) raises `mem_ack` for one cycle on the next cycle, with `mem_rdata` = 0. Any other size or address gives no `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | I/O port address |
| io_rd | input | 1 | One-cycle read strobe |
| io_wr | input | 1 | One-cycle write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| mem_addr | input | 32 | Memory window address |
| mem_rd | input | 1 | Memory read strobe |
| mem_size | input | 2 | Access size code (2'b10 = 32-bit) |
| mem_ack | output | 1 | Memory read accepted |
| mem_rdata | output | 32 | Memory read data |
| soft_reset | output | 1 | Soft-reset request |
| map_noncontig | output | 1 | Non-contiguous I/O map mode |
| endian_err | output | 1 | Sticky unsupported-mode error |

## Verification
The bench builds the block with `EQUIP_VAL` = 0x5A and `BOARD_ID` = 0xC3 instead of the zero defaults. With these values a swapped or stuck read path on the two identity ports shows up, which it would not against zeros. The parity window keeps its default base. This makes the exact-address and size filtering reachable with addresses one word on either side of the window. Random writes of full bytes to the masked ports check the field filtering and the sticky error against a bench model.

// File: rtl/sysio_pkg.sv
package sysio_pkg;
   localparam int NPORTS = 10;

   // port slot indices
   localparam int P_SRST  = 0;
   localparam int P_LIGHT = 1;
   localparam int P_EQUIP = 2;
   localparam int P_PW1   = 3;
   localparam int P_PW2   = 4;
   localparam int P_L2INV = 5;
   localparam int P_KEY   = 6;
   localparam int P_SCTL  = 7;
   localparam int P_MAP   = 8;
   localparam int P_BID   = 9;

   localparam logic [15:0] PORT_ADDR [NPORTS] = '{
      16'h0092, 16'h0808, 16'h080C, 16'h0810, 16'h0812,
      16'h0814, 16'h0818, 16'h081C, 16'h0850, 16'h0852};

   // slots that answer reads with real data
   localparam logic [NPORTS-1:0] READABLE =
      (NPORTS'(1) << P_SRST) | (NPORTS'(1) << P_EQUIP) | (NPORTS'(1) << P_KEY) |
      (NPORTS'(1) << P_SCTL) | (NPORTS'(1) << P_MAP)   | (NPORTS'(1) << P_BID);

   // reversed numbering: logical bit n lives on data bit 7-n
   function automatic int dbit(input int n);
      return 7 - n;
   endfunction

   localparam int SRST_BIT = dbit(7);
   localparam int LE_BIT   = dbit(6);
   localparam int MAP_BIT  = dbit(7);
   localparam logic [7:0] SCTL_MASK =
      (8'd1 << dbit(0)) | (8'd1 << dbit(1)) | (8'd1 << dbit(2)) | (8'd1 << dbit(3));

   localparam logic [1:0] SIZE_WORD = 2'b10;
endpackage

// File: rtl/sysio_port_decode.sv
module sysio_port_decode
   import sysio_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0]  addr,
   output logic [NPORTS-1:0]  hit
);
   generate
      if (ADDR_W < 12 || ADDR_W > 16) begin : g_bad_width
         $error("sysio_port_decode: ADDR_W must lie in 12..16");
      end
      for (genvar i = 0; i < NPORTS; i++) begin : g_cmp
         assign hit[i] = (addr == ADDR_W'(PORT_ADDR[i]));
      end
   endgenerate

   always_comb begin
      assert_hit_unique_R8: assert ($onehot0(hit))
         else $error("port decode produced multiple hits");
   end
endmodule

// File: rtl/sysio_reg_bank.sv
module sysio_reg_bank
   import sysio_pkg::*;
#(
   parameter logic [7:0] EQUIP_VAL = 8'h00,
   parameter logic [7:0] BOARD_ID  = 8'h00
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd,
   input  logic              wr,
   input  logic [7:0]        wdata,
   input  logic [NPORTS-1:0] hit,
   output logic [7:0]        rdata,
   output logic              soft_reset,
   output logic              map_noncontig,
   output logic              endian_err
);
   logic       srst_q, err_q, map_q;
   logic [7:0] sctl_q, rdata_q, rd_mux;

   always_comb begin
      rd_mux = 8'hFF;
      if (|(hit & READABLE)) begin
         rd_mux = 8'h00;
         if (hit[P_SRST])  rd_mux[SRST_BIT] = srst_q;
         if (hit[P_EQUIP]) rd_mux = EQUIP_VAL;
         if (hit[P_SCTL])  rd_mux = sctl_q;
         if (hit[P_MAP])   rd_mux[MAP_BIT] = map_q;
         if (hit[P_BID])   rd_mux = BOARD_ID;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         srst_q  <= 1'b0;
         err_q   <= 1'b0;
         map_q   <= 1'b1;
         sctl_q  <= 8'h00;
         rdata_q <= 8'h00;
      end else begin
         if (wr) begin
            if (hit[P_SRST]) begin
               srst_q <= wdata[SRST_BIT];
               if (wdata[LE_BIT]) err_q <= 1'b1;
            end
            if (hit[P_SCTL]) sctl_q <= wdata & SCTL_MASK;
            if (hit[P_MAP])  map_q  <= wdata[MAP_BIT];
         end
         if (rd) rdata_q <= rd_mux;
      end
   end

   assign rdata         = rdata_q;
   assign soft_reset    = srst_q;
   assign map_noncontig = map_q;
   assign endian_err    = err_q;

   assert_srst_follow_R2: assert property (@(posedge clk) disable iff (rst)
      (wr && hit[P_SRST]) |=> (soft_reset == $past(wdata[SRST_BIT])));
   assert_err_sticky_R3: assert property (@(posedge clk) disable iff (rst)
      endian_err |=> endian_err);
   assert_err_cause_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(endian_err) |-> $past(wr && hit[P_SRST] && wdata[LE_BIT]));
   assert_sctl_mask_R4: assert property (@(posedge clk) disable iff (rst)
      (rd && hit[P_SCTL]) |=> (rdata[3:0] == 4'h0));
   assert_map_follow_R5: assert property (@(posedge clk) disable iff (rst)
      (wr && hit[P_MAP]) |=> (map_noncontig == $past(wdata[MAP_BIT])));
   assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !rd |=> $stable(rdata));
endmodule

// File: rtl/sysio_parity_window.sv
module sysio_parity_window
   import sysio_pkg::*;
#(
   parameter logic [31:0] PARITY_BASE = 32'hBFFF_EFF0,
   parameter bit          ENABLE      = 1'b1
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        mem_rd,
   input  logic [31:0] mem_addr,
   input  logic [1:0]  mem_size,
   output logic        mem_ack,
   output logic [31:0] mem_rdata
);
   generate
      if (PARITY_BASE[1:0] != 2'b00) begin : g_bad_base
         $error("sysio_parity_window: PARITY_BASE must be word aligned");
      end
      if (ENABLE) begin : g_win
         logic ack_q;
         always_ff @(posedge clk) begin
            if (rst) ack_q <= 1'b0;
            else     ack_q <= mem_rd && (mem_size == SIZE_WORD) &&
                              (mem_addr == PARITY_BASE);
         end
         assign mem_ack   = ack_q;
         assign mem_rdata = 32'h0;

         assert_ack_cause_R10: assert property (@(posedge clk) disable iff (rst)
            mem_ack |-> $past(mem_rd && mem_size == SIZE_WORD));
         assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (rst)
            (mem_ack && !$past(mem_rd)) |-> 1'b0);
      end else begin : g_nowin
         assign mem_ack   = 1'b0;
         assign mem_rdata = 32'h0;
      end
   endgenerate

   always_comb begin
      assert_rdata_zero_R10: assert (!mem_ack || mem_rdata == 32'h0)
         else $error("parity window returned nonzero");
   end
endmodule

// File: rtl/sysio_ctrl_regs.sv
module sysio_ctrl_regs
   import sysio_pkg::*;
#(
   parameter int          ADDR_W      = 16,
   parameter logic [7:0]  EQUIP_VAL   = 8'h00,
   parameter logic [7:0]  BOARD_ID    = 8'h00,
   parameter logic [31:0] PARITY_BASE = 32'hBFFF_EFF0,
   parameter bit          PARITY_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   input  logic [31:0]       mem_addr,
   input  logic              mem_rd,
   input  logic [1:0]        mem_size,
   output logic              mem_ack,
   output logic [31:0]       mem_rdata,
   output logic              soft_reset,
   output logic              map_noncontig,
   output logic              endian_err
);
   logic [NPORTS-1:0] hit;

   sysio_port_decode #(.ADDR_W(ADDR_W)) decode_i (
      .addr (io_addr),
      .hit  (hit)
   );

   sysio_reg_bank #(.EQUIP_VAL(EQUIP_VAL), .BOARD_ID(BOARD_ID)) bank_i (
      .clk           (clk),
      .rst           (rst),
      .rd            (io_rd),
      .wr            (io_wr),
      .wdata         (io_wdata),
      .hit           (hit),
      .rdata         (io_rdata),
      .soft_reset    (soft_reset),
      .map_noncontig (map_noncontig),
      .endian_err    (endian_err)
   );

   sysio_parity_window #(.PARITY_BASE(PARITY_BASE), .ENABLE(PARITY_EN)) win_i (
      .clk       (clk),
      .rst       (rst),
      .mem_rd    (mem_rd),
      .mem_addr  (mem_addr),
      .mem_size  (mem_size),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata)
   );

   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (map_noncontig && !soft_reset && !endian_err && io_rdata == 8'h00));
endmodule

// File: tb/sysio_ctrl_regs_tb.sv
`timescale 1ns/1ps
module sysio_ctrl_regs_tb_top;
   localparam logic [7:0] EQ  = 8'h5A;
   localparam logic [7:0] BID = 8'hC3;
   localparam logic [31:0] BASE = 32'hBFFF_EFF0;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [15:0] io_addr = '0;
   logic io_rd = 1'b0, io_wr = 1'b0;
   logic [7:0] io_wdata = '0, io_rdata;
   logic [31:0] mem_addr = '0, mem_rdata;
   logic mem_rd = 1'b0, mem_ack;
   logic [1:0] mem_size = '0;
   logic soft_reset, map_noncontig, endian_err;

   int n_tests = 0, n_fail = 0;

   // bench model
   logic m_srst, m_err, m_map;
   logic [7:0] m_sctl, m_rdata;

   always #2 clk = ~clk;

   sysio_ctrl_regs #(.ADDR_W(16), .EQUIP_VAL(EQ), .BOARD_ID(BID)) dut_i (
      .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_addr(mem_addr),
      .mem_rd(mem_rd), .mem_size(mem_size), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .soft_reset(soft_reset),
      .map_noncontig(map_noncontig), .endian_err(endian_err));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_read(input logic [15:0] a);
      case (a)
         16'h0092: return {7'b0, m_srst};
         16'h080C: return EQ;
         16'h0852: return BID;
         16'h0818: return 8'h00;
         16'h081C: return m_sctl;
         16'h0850: return {7'b0, m_map};
         default:  return 8'hFF;
      endcase
   endfunction

   task automatic model_reset();
      m_srst = 0; m_err = 0; m_map = 1; m_sctl = 0; m_rdata = 0;
   endtask

   task automatic check_outs(input string req);
      chk({req, " soft_reset"}, soft_reset, m_srst);
      chk({req, " map_noncontig"}, map_noncontig, m_map);
      chk({req, " endian_err"}, endian_err, m_err);
   endtask

   task automatic do_write(input logic [15:0] a, input logic [7:0] d, input string req);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
      case (a)
         16'h0092: begin m_srst = d[0]; if (d[1]) m_err = 1'b1; end
         16'h081C: m_sctl = d & 8'hF0;
         16'h0850: m_map = d[0];
         default: ;
      endcase
      check_outs(req);
   endtask

   task automatic do_read(input logic [15:0] a, input string req);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
      m_rdata = exp_read(a);
      chk(req, io_rdata, m_rdata);
   endtask

   task automatic do_mem(input logic [31:0] a, input logic [1:0] sz);
      logic e;
      @(negedge clk);
      mem_addr = a; mem_size = sz; mem_rd = 1'b1;
      @(negedge clk);
      mem_rd = 1'b0;
      e = (a == BASE) && (sz == 2'b10);
      chk("R10 mem_ack", mem_ack, e);
      if (e) chk("R10 mem_rdata", mem_rdata, 32'h0);
      @(negedge clk);
      chk("R10 ack single cycle", mem_ack, 1'b0);
   endtask

   localparam logic [15:0] CAND [14] = '{
      16'h0092, 16'h0808, 16'h080C, 16'h0810, 16'h0812, 16'h0814, 16'h0818,
      16'h081C, 16'h0850, 16'h0852, 16'h0093, 16'h0800, 16'h0851, 16'h081D};

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      model_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      check_outs("R1 reset");
      chk("R1 reset rdata", io_rdata, 8'h00);
      do_read(16'h081C, "R1 sctl reset");

      // directed corners
      do_write(16'h0092, 8'h01, "R2 set srst");
      do_read(16'h0092, "R2 read srst");
      do_write(16'h0092, 8'hFC, "R2 clear srst");
      do_read(16'h0092, "R2 read cleared");
      do_write(16'h0092, 8'h03, "R3 le request");
      do_read(16'h0092, "R3 le bit not stored");
      do_write(16'h0092, 8'h00, "R3 err sticky");
      do_write(16'h081C, 8'hFF, "R4 write all ones");
      do_read(16'h081C, "R4 masked read");
      do_write(16'h0850, 8'hFE, "R5 clear map");
      do_read(16'h0850, "R5 read map");
      do_write(16'h080C, 8'h00, "R6 write equip");
      do_read(16'h080C, "R6 equip");
      do_write(16'h0852, 8'hFF, "R6 write board id");
      do_read(16'h0852, "R6 board id");
      do_write(16'h0818, 8'hFF, "R7 write keylock");
      do_read(16'h0818, "R7 keylock");
      do_write(16'h0808, 8'hFF, "R8 light");
      do_write(16'h0810, 8'hFF, "R8 pw1");
      do_write(16'h0812, 8'hFF, "R8 pw2");
      do_write(16'h0814, 8'hFF, "R8 l2inv");
      do_write(16'h0093, 8'hFF, "R8 undecoded");
      do_read(16'h0814, "R8 wo read");
      do_read(16'h081C, "R8 sctl untouched");
      do_read(16'h1234, "R8 undecoded read");
      do_read(16'h0852, "R9 read");
      repeat (3) @(negedge clk);
      chk("R9 rdata held", io_rdata, m_rdata);

      do_mem(BASE, 2'b10);
      do_mem(BASE, 2'b01);
      do_mem(BASE + 32'd4, 2'b10);
      do_mem(BASE - 32'd4, 2'b10);
      do_mem(BASE + 32'd2, 2'b10);

      // mid-run reset
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      model_reset();
      check_outs("R1 second reset");
      chk("R1 second reset rdata", io_rdata, 8'h00);

      // constrained random
      for (int i = 0; i < 400; i++) begin
         logic [15:0] a;
         logic [7:0]  d;
         a = ($urandom_range(0, 9) == 0) ? 16'($urandom) : CAND[$urandom_range(0, 13)];
         d = 8'($urandom);
         if (a == 16'h0092 && $urandom_range(0, 7) != 0) d[1] = 1'b0;
         case ($urandom_range(0, 2))
            0: do_write(a, d, "R2-R8 random write");
            1: do_read(a, "R9 random read");
            default: do_mem(($urandom_range(0, 1) == 0) ? BASE : 32'($urandom),
                            2'($urandom_range(0, 3)));
         endcase
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule